// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out a single set-vector-length operation against a 64-bit vector state word. The word holds a 7-bit maximum vector length (MVL) and a 7-bit current vector length (VL). The operation arrives as a 32-bit instruction word, qualified by a valid strobe. With it come the value of the named source register, the loop counter value and the current state word.

The unit picks the new MVL from either the instruction immediate or the existing state. It picks the new VL from one of four sources: the old VL, the register value, the loop counter, or the immediate. Each source is saturated to 127 and then limited to the new MVL, and a single overflow flag records any reduction. When a length is actually written, the unit also rewrites two mode bits.

All results are registered and appear one clock after the strobe. They are the new state word, an optional register write of the resulting VL, the overflow flag and an optional 4-bit condition field. The register file and the state register itself live outside this unit.

Top module: `vlcfg_unit`

## Requirements
- R1: Instruction bits use MSB-0 numbering (MSB-0 bit n is `insn_i[31-n]`). RT is bits 6:10, RA is bits 11:15, the 7-bit immediate is bits 16:22, and the flags are ms at bit 23, vs at bit 24, vf at bit 25 and Rc at bit 31. The working immediate is (immediate + 1) mod 128. When ms=1, the new MVL equals the working immediate.
- R2: The state word uses MSB-0 numbering: MVL is `state[63:57]` and VL is `state[56:50]`. When ms=0, the new MVL equals the old MVL.
- R3: When vs=0, the VL chosen before clamping is the old VL.
- R4: When vs=1 and RA≠0, the VL is the register value. If that value is unsigned-greater than 127, the VL is 127 and overflow is set.
- R5: When vs=1, RA=0 and RT=0, the VL is the working immediate.
- R6: When vs=1, RA=0 and RT≠0, the VL is the loop counter, saturating to 127 with overflow.
- R7: If the chosen VL exceeds the new MVL, VL becomes MVL and overflow is set. A VL equal to MVL is not reduced. Overflow is clear when neither saturation nor clamping happened.
- R8: When RT≠0, a register write is issued to index RT with VL zero-extended to 64 bits. When RT=0, no register write is issued.
- R9: When vs=1 or ms=1, state bit 0 (vertical-first) takes vf and state bit 1 (persist) is cleared. Otherwise both bits keep their values.
- R10: State bits 49:2 pass through unchanged.
- R11: When Rc=1, a condition write is issued with `cr[3]`=(VL==0), `cr[2]`=(VL!=0), `cr[1]`=0 and `cr[0]`=overflow. When Rc=0, no condition write is issued.
- R12: Outputs change only one clock after valid_i. All write strobes are low in cycles that follow a cycle without valid_i. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| insn_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of the register named by RA |
| ctr_i | input | 64 | Loop counter value |
| state_i | input | 64 | Current vector state word |
| state_we_o | output | 1 | State write strobe |
| state_o | output | 64 | Updated state word |
| rt_we_o | output | 1 | Destination register write strobe |
| rt_idx_o | output | 5 | Destination register index |
| rt_data_o | output | 64 | Destination register data (zero-extended VL) |
| ovf_o | output | 1 | Overflow flag |
| cr_we_o | output | 1 | Condition field write strobe |
| cr_o | output | 4 | Condition field |

## Verification
Source saturation and MVL clamping can both reduce the length in one operation, and both feed the same overflow flag. The bench provokes this by setting a small MVL through ms while supplying a register value above 127, and by saturating the loop counter against a reduced MVL. In each case the result must be the new MVL with a single overflow indication. A behavioural reference model in the bench predicts every output on every clock, and random operations that mix the ms, vs, RA and RT selections repeat this coincidence many times.

// File: rtl/vlcfg_pkg.sv
`timescale 1ns/1ps
package vlcfg_pkg;
  localparam int INSN_W = 32;
  localparam int FLD_W  = 7;
  localparam int RIDX_W = 5;
  localparam int CR_W   = 4;

  typedef struct packed {
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] ra;
    logic [FLD_W-1:0]  imm;
    logic              ms;
    logic              vs;
    logic              vf;
    logic              rc;
  } vl_op_t;
endpackage

// File: rtl/vlcfg_sat.sv
`timescale 1ns/1ps
module vlcfg_sat #(
  parameter int IW = 64,
  parameter int OW = 7
) (
  input  logic [IW-1:0] val_i,
  output logic [OW-1:0] val_o,
  output logic          sat_o
);
  assign sat_o = |val_i[IW-1:OW];
  assign val_o = sat_o ? {OW{1'b1}} : val_i[OW-1:0];
endmodule

// File: rtl/vlcfg_select.sv
`timescale 1ns/1ps
module vlcfg_select #(
  parameter int LW = 7
) (
  input  logic          vs_i,
  input  logic          ra_nz_i,
  input  logic          rt_nz_i,
  input  logic [LW-1:0] old_vl_i,
  input  logic [LW-1:0] imm_i,
  input  logic [LW-1:0] reg_vl_i,
  input  logic          reg_sat_i,
  input  logic [LW-1:0] ctr_vl_i,
  input  logic          ctr_sat_i,
  output logic [LW-1:0] vl_o,
  output logic          ovf_o
);
  always_comb begin
    vl_o  = old_vl_i;
    ovf_o = 1'b0;
    if (vs_i) begin
      if (ra_nz_i) begin
        vl_o  = reg_vl_i;
        ovf_o = reg_sat_i;
      end else if (!rt_nz_i) begin
        vl_o = imm_i;
      end else begin
        vl_o  = ctr_vl_i;
        ovf_o = ctr_sat_i;
      end
    end
  end

  // R4 R6
  always_comb begin
    sat_src_chk: assert (!ovf_o || vs_i);
  end
endmodule

// File: rtl/vlcfg_clamp.sv
`timescale 1ns/1ps
module vlcfg_clamp #(
  parameter int LW = 7
) (
  input  logic [LW-1:0] vl_i,
  input  logic          ovf_i,
  input  logic [LW-1:0] mvl_i,
  output logic [LW-1:0] vl_o,
  output logic          ovf_o
);
  logic over;
  assign over  = vl_i > mvl_i;
  assign vl_o  = over ? mvl_i : vl_i;
  assign ovf_o = ovf_i | over;

  // R7
  always_comb begin
    vl_le_mvl_chk: assert (vl_o <= mvl_i);
  end
endmodule

// File: rtl/vlcfg_unit.sv
`timescale 1ns/1ps
module vlcfg_unit #(
  parameter int XLEN = 64,
  parameter int LW   = vlcfg_pkg::FLD_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        valid_i,
  input  logic [vlcfg_pkg::INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]             ra_val_i,
  input  logic [XLEN-1:0]             ctr_i,
  input  logic [XLEN-1:0]             state_i,
  output logic                        state_we_o,
  output logic [XLEN-1:0]             state_o,
  output logic                        rt_we_o,
  output logic [vlcfg_pkg::RIDX_W-1:0] rt_idx_o,
  output logic [XLEN-1:0]             rt_data_o,
  output logic                        ovf_o,
  output logic                        cr_we_o,
  output logic [vlcfg_pkg::CR_W-1:0]  cr_o
);
  import vlcfg_pkg::*;

  localparam int MVL_HI  = XLEN - 1;
  localparam int VL_HI   = XLEN - 1 - LW;
  localparam int PASS_HI = XLEN - 1 - 2 * LW;
  localparam int PERSIST = 1;
  localparam int VFIRST  = 0;
  localparam int NSRC    = 2;

  // MSB-0 field n sits at insn_i[INSN_W-1-n]
  vl_op_t op;
  assign op.rt  = insn_i[INSN_W-7  -: RIDX_W];
  assign op.ra  = insn_i[INSN_W-12 -: RIDX_W];
  assign op.imm = insn_i[INSN_W-17 -: FLD_W];
  assign op.ms  = insn_i[INSN_W-24];
  assign op.vs  = insn_i[INSN_W-25];
  assign op.vf  = insn_i[INSN_W-26];
  assign op.rc  = insn_i[INSN_W-32];

  logic unused_opcode_bits;
  assign unused_opcode_bits = ^{insn_i[INSN_W-1 -: 6], insn_i[5:1]};

  logic [LW-1:0] imm_w, old_mvl, old_vl, new_mvl;
  assign imm_w   = op.imm + LW'(1);
  assign old_mvl = state_i[MVL_HI -: LW];
  assign old_vl  = state_i[VL_HI -: LW];
  assign new_mvl = op.ms ? imm_w : old_mvl;

  // wide sources: index 0 register value, index 1 loop counter
  logic [NSRC-1:0][XLEN-1:0] wide_src;
  logic [NSRC-1:0][LW-1:0]   narrow_src;
  logic [NSRC-1:0]           src_sat;
  assign wide_src[0] = ra_val_i;
  assign wide_src[1] = ctr_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_sat
    vlcfg_sat #(.IW(XLEN), .OW(LW)) u_sat (
      .val_i(wide_src[g]),
      .val_o(narrow_src[g]),
      .sat_o(src_sat[g])
    );
  end

  logic [LW-1:0] vl_raw, vl_fin;
  logic          ovf_raw, ovf_fin;

  vlcfg_select #(.LW(LW)) u_sel (
    .vs_i     (op.vs),
    .ra_nz_i  (op.ra != '0),
    .rt_nz_i  (op.rt != '0),
    .old_vl_i (old_vl),
    .imm_i    (imm_w),
    .reg_vl_i (narrow_src[0]),
    .reg_sat_i(src_sat[0]),
    .ctr_vl_i (narrow_src[1]),
    .ctr_sat_i(src_sat[1]),
    .vl_o     (vl_raw),
    .ovf_o    (ovf_raw)
  );

  vlcfg_clamp #(.LW(LW)) u_clamp (
    .vl_i (vl_raw),
    .ovf_i(ovf_raw),
    .mvl_i(new_mvl),
    .vl_o (vl_fin),
    .ovf_o(ovf_fin)
  );

  logic [XLEN-1:0] state_n;
  logic [CR_W-1:0] cr_n;
  always_comb begin
    state_n                = state_i;
    state_n[MVL_HI -: LW]  = new_mvl;
    state_n[VL_HI -: LW]   = vl_fin;
    if (op.vs || op.ms) begin
      state_n[VFIRST]  = op.vf;
      state_n[PERSIST] = 1'b0;
    end
    cr_n = {vl_fin == '0, vl_fin != '0, 1'b0, ovf_fin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_we_o <= 1'b0;
      state_o    <= '0;
      rt_we_o    <= 1'b0;
      rt_idx_o   <= '0;
      rt_data_o  <= '0;
      ovf_o      <= 1'b0;
      cr_we_o    <= 1'b0;
      cr_o       <= '0;
    end else begin
      state_we_o <= valid_i;
      rt_we_o    <= valid_i && (op.rt != '0);
      cr_we_o    <= valid_i && op.rc;
      if (valid_i) begin
        state_o   <= state_n;
        rt_idx_o  <= op.rt;
        rt_data_o <= {{(XLEN-LW){1'b0}}, vl_fin};
        ovf_o     <= ovf_fin;
        cr_o      <= cr_n;
      end
    end
  end

  // R12
  valid_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> state_we_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !(state_we_o || rt_we_o || cr_we_o));

  // R7
  vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    state_we_o |-> (state_o[VL_HI -: LW] <= state_o[MVL_HI -: LW]));

  // R8
  rt_zext_chk: assert property (@(posedge clk) disable iff (rst)
    rt_we_o |-> (rt_data_o[XLEN-1:LW] == '0 &&
                 rt_data_o[LW-1:0] == state_o[VL_HI -: LW]));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !op.vs && !op.ms) |=> state_o[PERSIST:VFIRST] == $past(state_i[PERSIST:VFIRST]));

  // R10
  pass_bits_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> state_o[PASS_HI:2] == $past(state_i[PASS_HI:2]));

  // R11
  cr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we_o |-> $onehot(cr_o[3:2]));
endmodule

// File: tb/vlcfg_unit_tb.sv
`timescale 1ns/1ps
module vlcfg_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] ra_val_i = '0, ctr_i = '0, state_i = '0;
  logic        state_we_o, rt_we_o, ovf_o, cr_we_o;
  logic [63:0] state_o, rt_data_o;
  logic [4:0]  rt_idx_o;
  logic [3:0]  cr_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vlcfg_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i),
    .ra_val_i(ra_val_i), .ctr_i(ctr_i), .state_i(state_i),
    .state_we_o(state_we_o), .state_o(state_o), .rt_we_o(rt_we_o),
    .rt_idx_o(rt_idx_o), .rt_data_o(rt_data_o), .ovf_o(ovf_o),
    .cr_we_o(cr_we_o), .cr_o(cr_o)
  );

  // expected outputs
  logic        e_swe = 0, e_rtwe = 0, e_ovf = 0, e_crwe = 0;
  logic [63:0] e_state = '0, e_data = '0;
  logic [4:0]  e_idx = '0;
  logic [3:0]  e_cr = '0;
  string       cur_tag = "R12";

  task automatic ck(input string nm, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_tag, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    ck("state_we", 64'(state_we_o), 64'(e_swe));
    ck("state", state_o, e_state);
    ck("rt_we", 64'(rt_we_o), 64'(e_rtwe));
    ck("rt_idx", 64'(rt_idx_o), 64'(e_idx));
    ck("rt_data", rt_data_o, e_data);
    ck("ovf", 64'(ovf_o), 64'(e_ovf));
    ck("cr_we", 64'(cr_we_o), 64'(e_crwe));
    ck("cr", 64'(cr_o), 64'(e_cr));
  endtask

  function automatic logic [31:0] mk(input int rt, input int ra, input int svi,
                                     input bit ms, input bit vs, input bit vf, input bit rc);
    return {6'd22, 5'(rt), 5'(ra), 7'(svi), ms, vs, vf, 5'd27, rc};
  endfunction

  function automatic logic [63:0] mkst(input int mvl, input int vl, input logic [47:0] mid,
                                       input bit p, input bit vfb);
    return {7'(mvl), 7'(vl), mid, p, vfb};
  endfunction

  // behavioural reference for one operation
  task automatic predict(input bit v, input logic [31:0] w, input logic [63:0] rv,
                         input logic [63:0] cv, input logic [63:0] st);
    int rt, ra, svi, imm, mvl, vl;
    bit ms, vs, vf, rc, ov;
    if (!v) begin
      e_swe = 0; e_rtwe = 0; e_crwe = 0;
      return;
    end
    rt = int'(w[25:21]); ra = int'(w[20:16]); svi = int'(w[15:9]);
    ms = w[8]; vs = w[7]; vf = w[6]; rc = w[0];
    imm = (svi + 1) % 128;
    mvl = ms ? imm : int'(st[63:57]);
    ov = 0;
    if (!vs) vl = int'(st[56:50]);
    else if (ra != 0) begin
      if (rv > 64'd127) begin vl = 127; ov = 1; end
      else vl = int'(rv);
    end else if (rt == 0) vl = imm;
    else begin
      if (cv > 64'd127) begin vl = 127; ov = 1; end
      else vl = int'(cv);
    end
    if (vl > mvl) begin vl = mvl; ov = 1; end
    e_state = st;
    e_state[63:57] = 7'(mvl);
    e_state[56:50] = 7'(vl);
    if (vs || ms) begin e_state[0] = vf; e_state[1] = 1'b0; end
    e_swe = 1;
    e_rtwe = (rt != 0);
    e_idx = 5'(rt);
    e_data = 64'(vl);
    e_ovf = ov;
    e_crwe = rc;
    e_cr = {vl == 0, vl != 0, 1'b0, ov};
  endtask

  task automatic step(input string tag, input bit v, input logic [31:0] w,
                      input logic [63:0] rv, input logic [63:0] cv, input logic [63:0] st);
    @(negedge clk);
    compare_all();
    cur_tag = tag;
    valid_i = v; insn_i = w; ra_val_i = rv; ctr_i = cv; state_i = st;
    predict(v, w, rv, cv, st);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R12";
    compare_all();   // reset state, R12
    rst = 1'b0;
    // R1: ms sets MVL from immediate+1
    step("R1", 1, mk(0, 0, 15, 1, 0, 0, 0), 0, 0, mkst(90, 5, 48'h0, 0, 0));
    // R1: immediate 127 wraps to 0, VL clamped
    step("R1", 1, mk(0, 0, 127, 1, 0, 0, 1), 0, 0, mkst(90, 5, 48'h0, 0, 0));
    // R2: ms=0 keeps MVL, VL from register
    step("R2", 1, mk(0, 3, 0, 0, 1, 0, 0), 64'd20, 0, mkst(100, 9, 48'h0, 0, 0));
    // R3: vs=0 keeps VL; R9 mode bits held
    step("R3", 1, mk(0, 0, 0, 0, 0, 1, 1), 0, 0, mkst(100, 40, 48'h0, 1, 0));
    // R4: register above 127 saturates
    step("R4", 1, mk(0, 7, 126, 1, 1, 0, 1), 64'h100, 0, mkst(3, 3, 48'h0, 0, 0));
    // R4: register exactly 127, no overflow
    step("R4", 1, mk(0, 7, 126, 1, 1, 0, 1), 64'd127, 0, mkst(3, 3, 48'h0, 0, 0));
    // R5: immediate source
    step("R5", 1, mk(0, 0, 9, 0, 1, 0, 0), 64'd99, 64'd77, mkst(50, 0, 48'h0, 0, 0));
    // R6: loop counter source with register write
    step("R6", 1, mk(4, 0, 0, 0, 1, 0, 1), 0, 64'd33, mkst(127, 0, 48'h0, 0, 0));
    // R6: counter saturation
    step("R6", 1, mk(4, 0, 0, 0, 1, 0, 1), 0, 64'hFFFF_FFFF_0000_0000, mkst(127, 0, 48'h0, 0, 0));
    // R7: saturation and clamp in the same operation
    step("R7", 1, mk(2, 2, 9, 1, 1, 0, 1), 64'd300, 0, mkst(0, 0, 48'h0, 0, 0));
    // R7: counter saturation against reduced MVL
    step("R7", 1, mk(6, 0, 19, 1, 1, 0, 1), 0, 64'd5000, mkst(0, 0, 48'h0, 0, 0));
    // R7: VL equal to MVL, no overflow
    step("R7", 1, mk(2, 2, 9, 1, 1, 0, 1), 64'd10, 0, mkst(0, 0, 48'h0, 0, 0));
    // R8: RT zero gives no register write
    step("R8", 1, mk(0, 5, 0, 0, 1, 0, 0), 64'd12, 0, mkst(60, 0, 48'h0, 0, 0));
    // R9: ms sets vertical-first, clears persist
    step("R9", 1, mk(1, 0, 30, 1, 0, 1, 0), 0, 0, mkst(5, 4, 48'h0, 1, 0));
    // R10: middle bits pass through
    step("R10", 1, mk(3, 1, 0, 0, 1, 0, 0), 64'd7, 0, mkst(64, 2, 48'hA5C3_1234_FEDC, 1, 1));
    // R11: zero VL condition field
    step("R11", 1, mk(0, 0, 127, 0, 1, 1, 1), 0, 0, mkst(20, 20, 48'h0, 0, 0));
    // R11: Rc=0 no condition write
    step("R11", 1, mk(0, 0, 4, 0, 1, 1, 0), 0, 0, mkst(20, 20, 48'h0, 0, 0));
    // R12: idle cycles hold data, strobes low
    step("R12", 0, mk(9, 9, 9, 1, 1, 1, 1), 64'd1, 64'd1, 64'hFFFF);
    step("R12", 0, '0, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      logic [63:0] rv, cv;
      int ra, rt;
      ra = ($urandom % 3 == 0) ? 0 : int'($urandom % 32);
      rt = ($urandom % 3 == 0) ? 0 : int'($urandom % 32);
      rv = ($urandom % 2) ? 64'($urandom % 160) : {$urandom, $urandom};
      cv = ($urandom % 2) ? 64'($urandom % 160) : {$urandom, $urandom};
      step("R12", ($urandom % 5) != 0,
           mk(rt, ra, int'($urandom % 128), $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2),
           rv, cv, {$urandom, $urandom});
    end
    step("R12", 0, '0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R12 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule